// File: doc/BRIEF.md
# Fractional Line-Rate Frame Timing Generator

This block derives scan-line and frame timing directly from the system clock when the line period is not a whole number of clock cycles. A fixed-point accumulator with a 12-bit fractional part adds a per-line increment once per line. Its integer part sets how many cycles the current line lasts. The fractional remainder carries into the next line, so the average line rate is exact over time. No integer divider is involved.

Lines are counted within a frame whose length depends on the selected television standard: 263 lines for the 60 Hz standard and 313 lines for the 50 Hz standard. A vertical-blank request pulses when the line count reaches 240. When the last line ends, the count wraps to 0, a frame counter advances, and, if interlacing is enabled, an odd/even field bit follows the low bit of that counter. The single-cycle line tick can also serve as the alternate count source of a general-purpose timer.

The standard-select input is sampled only at frame boundaries. Reset puts the block into the 60 Hz standard with every count and the remainder cleared. The reset input is asynchronous and active low. Its release must already be synchronous to `clk`; that synchronisation is done at chip level.

Top module: `line_rate_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, line number, frame count, field bit and the vertical-blank request are 0, and no line tick is present.
- R2: Line k after reset lasts floor((k+1)·INC/4096) − floor(k·INC/4096) clock cycles, where INC is the 20.12 increment of the active standard: 8791293 for 60 Hz and 8864320 for 50 Hz. The 12-bit remainder is carried across line and frame boundaries.
- R3: `hsync_tick_o` is high for exactly one cycle, the last cycle of each line.
- R4: The line number changes only in the cycle after a tick, and it then increases by exactly one unless it wraps.
- R5: `vblank_irq_o` is a one-cycle pulse, raised in the first cycle of line 240 and at no other time.
- R6: After the last line of a frame the line number returns to 0: after line 262 in the 60 Hz standard and after line 312 in the 50 Hz standard.
- R7: The frame count increases by one at each wrap, and only then.
- R8: At each wrap the field bit takes the low bit of the new frame count if `ilace_en_i` is 1, and becomes 0 otherwise. It changes at no other time.
- R9: `std_sel_i` (0 = 60 Hz, 1 = 50 Hz) is adopted only at a frame wrap. A change during a frame leaves that frame's line lengths and line total unchanged.
- R10: Reset clears the fractional remainder, so line lengths after a reset in mid-line restart exactly as after power-up.
- R11: Over N lines of one standard starting from a cleared remainder, the total number of cycles equals floor(N·INC/4096).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| std_sel_i | input | 1 | Standard request: 0 = 60 Hz, 1 = 50 Hz |
| ilace_en_i | input | 1 | Enables the odd/even field bit |
| hsync_tick_o | output | 1 | One-cycle pulse on the last cycle of each line |
| vblank_irq_o | output | 1 | One-cycle vertical-blank request at the start of line 240 |
| line_o | output | LINE_W (9) | Current line within the frame |
| frame_o | output | FRAME_W (16) | Frame count, wraps modulo 2^FRAME_W |
| field_o | output | 1 | Odd/even field bit |

## Verification
The cycle-by-cycle rules are checked on every cycle by assertions:
- the tick lasts one cycle;
- the line number stays put between ticks and steps by one at a tick or wraps to 0;
- it stays inside the frame;
- the vertical-blank pulse appears only at the start of its line;
- the frame count and field bit move only at a wrap.

Other behaviour can be shown only by the bench's scenarios:
- the exact line lengths that come from the fractional carry, and the long-run cycle total;
- the deferred adoption of a new standard;
- the remainder being cleared by a reset in mid-line;
- the field value with interlace on and off.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

  localparam int FRAC_W = 12;

  typedef enum logic {
    STD_60 = 1'b0,
    STD_50 = 1'b1
  } std_e;

endpackage

// File: rtl/lrt_period_accum.sv
// Fixed-point accumulator: integer part of (remainder + increment) is the
// length of the current line; the fraction is kept for the next line.
module lrt_period_accum #(
  parameter int INC_W  = 24,
  parameter int FRAC_W = lrt_pkg::FRAC_W,
  localparam int PER_W = INC_W - FRAC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_end_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [PER_W-1:0] period_o
);

  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] frac_d;
  logic [INC_W:0]    sum;

  always_comb begin
    sum      = {1'b0, inc_i} + {{(INC_W + 1 - FRAC_W){1'b0}}, frac_q};
    period_o = sum[INC_W:FRAC_W];
    frac_d   = frac_q;
    if (line_end_i) begin
      frac_d = sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q <= '0;
    end else if (line_end_i) begin
      frac_q <= frac_d;
    end
  end

endmodule

// File: rtl/lrt_cycle_count.sv
// Counts the cycles of one line and flags its last cycle.
module lrt_cycle_count #(
  parameter int PER_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] cnt_d;
  logic [PER_W:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    tick_o  = (cnt_inc >= {1'b0, period_i});
    cnt_d   = tick_o ? '0 : cnt_inc[PER_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/lrt_frame_seq.sv
// Line / frame sequencing, vertical-blank pulse, field bit, standard latch.
module lrt_frame_seq
  import lrt_pkg::*;
#(
  parameter int LINES_60    = 263,
  parameter int LINES_50    = 313,
  parameter int VBLANK_LINE = 240,
  parameter int LINE_W      = 9,
  parameter int FRAME_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               std_sel_i,
  input  logic               ilace_i,
  output logic [LINE_W-1:0]  line_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               field_o,
  output logic               vblank_o,
  output std_e               std_o
);

  localparam logic [LINE_W-1:0] LAST_60 = LINE_W'(LINES_60 - 1);
  localparam logic [LINE_W-1:0] LAST_50 = LINE_W'(LINES_50 - 1);
  localparam logic [LINE_W-1:0] VB_LINE = LINE_W'(VBLANK_LINE);

  logic [LINE_W-1:0]  line_q,  line_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               field_q, field_d;
  logic               vb_q,    vb_d;
  std_e               std_q,   std_d;
  logic [LINE_W-1:0]  last_line;

  always_comb begin
    last_line = (std_q == STD_50) ? LAST_50 : LAST_60;
    line_d    = line_q;
    frame_d   = frame_q;
    field_d   = field_q;
    std_d     = std_q;
    vb_d      = 1'b0;
    if (tick_i) begin
      if (line_q == last_line) begin
        line_d  = '0;
        frame_d = frame_q + 1'b1;
        std_d   = std_e'(std_sel_i);
        field_d = ilace_i ? frame_d[0] : 1'b0;
      end else begin
        line_d  = line_q + 1'b1;
      end
      vb_d = (line_d == VB_LINE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      frame_q <= '0;
      field_q <= 1'b0;
      vb_q    <= 1'b0;
      std_q   <= STD_60;
    end else begin
      vb_q <= vb_d;
      if (tick_i) begin
        line_q  <= line_d;
        frame_q <= frame_d;
        field_q <= field_d;
        std_q   <= std_d;
      end
    end
  end

  assign line_o   = line_q;
  assign frame_o  = frame_q;
  assign field_o  = field_q;
  assign vblank_o = vb_q;
  assign std_o    = std_q;

endmodule

// File: rtl/line_rate_timer.sv
module line_rate_timer
  import lrt_pkg::*;
#(
  parameter int INC_60      = 8791293,
  parameter int INC_50      = 8864320,
  parameter int LINES_60    = 263,
  parameter int LINES_50    = 313,
  parameter int VBLANK_LINE = 240,
  parameter int FRAME_W     = 16,
  localparam int LINES_MAX  = (LINES_50 > LINES_60) ? LINES_50 : LINES_60,
  localparam int LINE_W     = $clog2(LINES_MAX),
  localparam int INC_MAX    = (INC_50 > INC_60) ? INC_50 : INC_60,
  localparam int INC_W      = $clog2(INC_MAX + 1),
  localparam int PER_W      = INC_W - FRAC_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               std_sel_i,
  input  logic               ilace_en_i,
  output logic               hsync_tick_o,
  output logic               vblank_irq_o,
  output logic [LINE_W-1:0]  line_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               field_o
);

  std_e             std_act;
  logic [INC_W-1:0] inc_sel;
  logic [PER_W-1:0] period;
  logic             tick;

  assign inc_sel = (std_act == STD_50) ? INC_W'(INC_50) : INC_W'(INC_60);

  lrt_period_accum #(
    .INC_W  (INC_W),
    .FRAC_W (FRAC_W)
  ) u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_end_i (tick),
    .inc_i      (inc_sel),
    .period_o   (period)
  );

  lrt_cycle_count #(
    .PER_W (PER_W)
  ) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period),
    .tick_o   (tick)
  );

  lrt_frame_seq #(
    .LINES_60    (LINES_60),
    .LINES_50    (LINES_50),
    .VBLANK_LINE (VBLANK_LINE),
    .LINE_W      (LINE_W),
    .FRAME_W     (FRAME_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .std_sel_i (std_sel_i),
    .ilace_i   (ilace_en_i),
    .line_o    (line_o),
    .frame_o   (frame_o),
    .field_o   (field_o),
    .vblank_o  (vblank_irq_o),
    .std_o     (std_act)
  );

  assign hsync_tick_o = tick;

endmodule

// File: rtl/line_rate_timer_chk.sv
module line_rate_timer_chk #(
  parameter int LINES_MAX   = 313,
  parameter int VBLANK_LINE = 240,
  parameter int LINE_W      = 9,
  parameter int FRAME_W     = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hsync_tick_o,
  input logic               vblank_irq_o,
  input logic [LINE_W-1:0]  line_o,
  input logic [FRAME_W-1:0] frame_o,
  input logic               field_o
);

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_tick_o |=> !hsync_tick_o); // R3

  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_tick_o |=> $stable(line_o)); // R4

  AST_LINE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_tick_o |=> ((line_o == $past(line_o) + 1'b1) || (line_o == '0))); // R4

  AST_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    line_o < LINE_W'(LINES_MAX)); // R6

  AST_VBLANK_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq_o |-> (line_o == LINE_W'(VBLANK_LINE)) && $past(hsync_tick_o)); // R5

  AST_VBLANK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq_o |=> !vblank_irq_o); // R5

  AST_FRAME_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_o) |-> (line_o == '0) && $past(hsync_tick_o)
                          && (frame_o == $past(frame_o) + 1'b1)); // R7

  AST_FIELD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_o) |-> (line_o == '0) && $past(hsync_tick_o)); // R8

endmodule

bind line_rate_timer line_rate_timer_chk #(
  .LINES_MAX   (LINES_MAX),
  .VBLANK_LINE (VBLANK_LINE),
  .LINE_W      (LINE_W),
  .FRAME_W     (FRAME_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hsync_tick_o (hsync_tick_o),
  .vblank_irq_o (vblank_irq_o),
  .line_o       (line_o),
  .frame_o      (frame_o),
  .field_o      (field_o)
);

// File: tb/line_rate_timer_tb.sv
`timescale 1ns/1ps
module line_rate_timer_tb;

  // Shrunk frame for simulation: 10.5 cycles/line (60), 12.25 (50).
  localparam int INC_60 = 43008;
  localparam int INC_50 = 50176;
  localparam int L60    = 7;
  localparam int L50    = 9;
  localparam int VBL    = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       std_sel;
  logic       ilace;
  logic       tick;
  logic       irq;
  logic [3:0] line;
  logic [15:0] frame;
  logic       field;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  line_rate_timer #(
    .INC_60 (INC_60), .INC_50 (INC_50),
    .LINES_60 (L60), .LINES_50 (L50),
    .VBLANK_LINE (VBL), .FRAME_W (16)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .std_sel_i (std_sel), .ilace_en_i (ilace),
    .hsync_tick_o (tick), .vblank_irq_o (irq),
    .line_o (line), .frame_o (frame), .field_o (field)
  );

  // {line length, line after tick, frame after tick, field after tick}
  localparam logic [31:0] TBL [0:13] = '{
    32'h0A_01_00_00, 32'h0B_02_00_00, 32'h0A_03_00_00, 32'h0B_04_00_00,
    32'h0A_05_00_00, 32'h0B_06_00_00, 32'h0A_00_01_01, 32'h0B_01_01_01,
    32'h0A_02_01_01, 32'h0B_03_01_01, 32'h0A_04_01_01, 32'h0B_05_01_01,
    32'h0A_06_01_01, 32'h0B_00_02_00
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called in the first cycle of a line; returns its length and stays in its last cycle.
  task automatic wait_tick(output int n);
    n = 1;
    while (!tick && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_reset_state(input string req);
    check(line == 0,  req, int'(line), 0);
    check(frame == 0, req, int'(frame), 0);
    check(field == 0, req, int'(field), 0);
    check(irq == 0,   req, int'(irq), 0);
    check(tick == 0,  req, int'(tick), 0);
  endtask

  initial begin
    int n;
    int sum;
    rst_n   = 1'b0;
    std_sel = 1'b0;
    ilace   = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("R1 in reset");
    rst_n = 1'b1;
    #0.1;
    check_reset_state("R1 after release");

    // Vector table: R2 line lengths, R4/R6 line, R7 frame, R8 field, R5 irq
    for (int k = 0; k < 14; k++) begin
      wait_tick(n);
      check(n == int'(TBL[k][31:24]), "R2 line length", n, int'(TBL[k][31:24]));
      @(negedge clk);
      check(line == TBL[k][19:16], "R4 line number", int'(line), int'(TBL[k][19:16]));
      check(frame == TBL[k][15:0] >> 8, "R7 frame count", int'(frame), int'(TBL[k][15:8]));
      check(field == TBL[k][0], "R8 field interlaced", int'(field), int'(TBL[k][0]));
      check(irq == (line == VBL), "R5 vblank pulse", int'(irq), int'(line == VBL));
    end

    // R9: request 50 Hz mid-frame; frame 2 keeps 60 Hz lengths and total
    wait_tick(n);
    check(n == 10, "R9 first line", n, 10);
    @(negedge clk);
    std_sel = 1'b1;
    sum = 0;
    for (int i = 0; i < 6; i++) begin
      wait_tick(n);
      sum += n;
      @(negedge clk);
    end
    check(sum == 63, "R9 lengths unchanged", sum, 63);
    check(line == 0, "R9 wrap at 60 Hz total", int'(line), 0);
    check(frame == 3, "R7 frame count", int'(frame), 3);
    check(field == 1, "R8 field odd", int'(field), 1);

    // R6: frame 3 in 50 Hz, 9 lines; interlace off for R8
    ilace = 1'b0;
    sum = 0;
    for (int i = 0; i < 9; i++) begin
      wait_tick(n);
      sum += n;
      @(negedge clk);
      if (i < 8) check(line == 4'(i + 1), "R6 no early wrap", int'(line), i + 1);
    end
    check(sum == 110, "R2 50 Hz frame cycles", sum, 110);
    check(line == 0, "R6 wrap at 50 Hz total", int'(line), 0);
    check(frame == 4, "R7 frame count", int'(frame), 4);
    check(field == 0, "R8 field with interlace off", int'(field), 0);

    // R10: reset in mid-line clears the remainder (0.75 left over here)
    repeat (5) @(negedge clk);
    std_sel = 1'b0;
    rst_n   = 1'b0;
    #0.1;
    check_reset_state("R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    wait_tick(n);
    check(n == 10, "R10 first line after reset", n, 10);
    sum = n;
    @(negedge clk);
    wait_tick(n);
    check(n == 11, "R10 second line after reset", n, 11);
    sum += n;
    @(negedge clk);

    // R11: 100 lines at 10.5 cycles = 1050 cycles
    for (int i = 2; i < 100; i++) begin
      wait_tick(n);
      sum += n;
      @(negedge clk);
    end
    check(sum == 1050, "R11 long-run total", sum, 1050);
    check(frame == 14, "R7 frame after 100 lines", int'(frame), 14);
    check(line == 2, "R6 line after 100 lines", int'(line), 2);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule